// File: doc/BRIEF.md
# DRAM controller register stub

This block is a small register file that answers in place of a DRAM controller's configuration registers. Boot firmware that starts DRAM init, data training and impedance calibration, and then polls for completion, finds each sequence already finished. No memory timing, PHY or training logic sits behind it. Only the completion handshake bits are modelled.

Access is through a simple 32-bit register bus: a byte offset inside a 4 KiB window, a write strobe with write data, and a read strobe. Read data comes back one clock later. Three registers hold state: a control word, a calibration setup word and a calibration status word. A start request in the control word reads back as clear at once. Any write to the calibration setup word sets the done flag in the status word. Other accesses return zero and pulse one of two error strobes: out-of-range or unimplemented.

Top module: `dramstub_top`

## Requirements
- R1: A synchronous active-low reset loads control (offset 0x000) with 0x80020000, calibration setup (0x0A8) with 0x07B00000 and calibration status (0x0B0) with 0x80000000. It also forces rdData, errRange and errUnimpl to 0.
- R2: For a read, rdData shows the addressed register one clock after rdEn. A write in the same cycle to the same offset does not affect that result, which is the value held before the write. With no read in the previous cycle, rdData is 0.
- R3: A write to control whose bit 31 (init request) is 1 stores bit 31 as 0.
- R4: A write to control stores bit 30 (training request) as 0. Bits 29:0 are stored as written.
- R5: A write to calibration setup stores the written value and sets bit 31 (calibration done) of calibration status. Bits 30:0 of the status are left unchanged.
- R6: A write to calibration status stores the written value as given.
- R7: An access at an offset from 0x2E4 to 0xFFF pulses errRange for one cycle, one clock after the access. A read there returns 0 and a write changes no register.
- R8: An access at any other offset below 0x2E4 that is none of the three registers pulses errUnimpl one clock later. A read there returns 0 and a write changes no register.
- R9: An access whose offset has bits [1:0] not zero is dropped and pulses errRange one clock later. A read returns 0 and a write changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | 12 | Byte offset inside the window |
| wrEn | input | 1 | Write strobe |
| wrData | input | 32 | Write data |
| rdEn | input | 1 | Read strobe |
| rdData | output | 32 | Registered read data |
| errRange | output | 1 | Pulse for an out-of-range or misaligned access |
| errUnimpl | output | 1 | Pulse for an unimplemented in-window offset |

## Verification
Some properties are checked on every cycle:
- after a control write, both request bits are clear;
- after a calibration setup write, the done flag is set;
- a cycle that writes no register leaves all three registers unchanged;
- rdData is zero after a cycle without a read;
- the two error strobes never rise together, and neither rises after an idle cycle.

Only the bench scenarios can show the rest:
- that the stored values and reset values are exact;
- that the unrequested control bits pass through unchanged;
- that a read in the same cycle as a write returns the old value;
- which strobe each class of offset raises.

// File: rtl/dramstub_pkg.sv
package dramstub_pkg;

  localparam int DATA_W = 32;
  localparam int ADDR_W = 12;

  // Implemented register offsets and start of the out-of-range area
  localparam int OFS_CTRL    = 'h000;
  localparam int OFS_CALCFG  = 'h0A8;
  localparam int OFS_CALSTAT = 'h0B0;
  localparam int OFS_OOR     = 'h2E4;

  // Reset contents
  localparam logic [DATA_W-1:0] RST_CTRL    = 32'h8002_0000;
  localparam logic [DATA_W-1:0] RST_CALCFG  = 32'h07B0_0000;
  localparam logic [DATA_W-1:0] RST_CALSTAT = 32'h8000_0000;

  // Handshake bit positions
  localparam int INIT_BIT  = 31;
  localparam int TRAIN_BIT = 30;
  localparam int DONE_BIT  = 31;

  typedef enum logic [1:0] {
    SEL_NONE    = 2'd0,
    SEL_CTRL    = 2'd1,
    SEL_CALCFG  = 2'd2,
    SEL_CALSTAT = 2'd3
  } regSel_e;

  // Strobes from the control module to the datapath
  typedef struct packed {
    regSel_e wrSel;
    regSel_e rdSel;
    logic    rdAct;
  } stubStrb_t;

endpackage

// File: rtl/dramstub_ctrl.sv
module dramstub_ctrl
  import dramstub_pkg::*;
#(
  parameter int ADDR_W_P = ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W_P-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output stubStrb_t         strb,
  output logic              errRange,
  output logic              errUnimpl
);

  localparam logic [ADDR_W_P-1:0] OOR_BASE  = ADDR_W_P'(OFS_OOR);
  localparam logic [ADDR_W_P-1:0] A_CTRL    = ADDR_W_P'(OFS_CTRL);
  localparam logic [ADDR_W_P-1:0] A_CALCFG  = ADDR_W_P'(OFS_CALCFG);
  localparam logic [ADDR_W_P-1:0] A_CALSTAT = ADDR_W_P'(OFS_CALSTAT);

  logic    misaligned;
  logic    outOfRange;
  logic    anyAccess;
  logic    unimplHit;
  regSel_e hitSel;

  always_comb begin
    misaligned = |addr[1:0];
    outOfRange = misaligned || (addr >= OOR_BASE);
    anyAccess  = wrEn || rdEn;
    if (misaligned)             hitSel = SEL_NONE;
    else if (addr == A_CTRL)    hitSel = SEL_CTRL;
    else if (addr == A_CALCFG)  hitSel = SEL_CALCFG;
    else if (addr == A_CALSTAT) hitSel = SEL_CALSTAT;
    else                        hitSel = SEL_NONE;
    unimplHit = !outOfRange && (hitSel == SEL_NONE);
  end

  always_comb begin
    strb.wrSel = wrEn ? hitSel : SEL_NONE;
    strb.rdSel = rdEn ? hitSel : SEL_NONE;
    strb.rdAct = rdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      errRange  <= 1'b0;
      errUnimpl <= 1'b0;
    end else begin
      errRange  <= anyAccess && outOfRange;
      errUnimpl <= anyAccess && unimplHit;
    end
  end

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errRange, errUnimpl}));

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn || rdEn) |=> !errRange && !errUnimpl);

endmodule

// File: rtl/dramstub_regs.sv
module dramstub_regs
  import dramstub_pkg::*;
#(
  parameter int DATA_W_P = DATA_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  stubStrb_t           strb,
  input  logic [DATA_W_P-1:0] wrData,
  output logic [DATA_W_P-1:0] rdData
);

  localparam logic [DATA_W_P-1:0] REQ_MASK =
    (DATA_W_P'(1) << INIT_BIT) | (DATA_W_P'(1) << TRAIN_BIT);

  logic [DATA_W_P-1:0] ctrlQ;
  logic [DATA_W_P-1:0] calCfgQ;
  logic [DATA_W_P-1:0] calStatQ;
  logic [DATA_W_P-1:0] rdMux;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= DATA_W_P'(RST_CTRL);
      calCfgQ  <= DATA_W_P'(RST_CALCFG);
      calStatQ <= DATA_W_P'(RST_CALSTAT);
    end else begin
      unique case (strb.wrSel)
        SEL_CTRL:    ctrlQ <= wrData & ~REQ_MASK;
        SEL_CALCFG: begin
          calCfgQ            <= wrData;
          calStatQ[DONE_BIT] <= 1'b1;
        end
        SEL_CALSTAT: calStatQ <= wrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (strb.rdSel)
      SEL_CTRL:    rdMux = ctrlQ;
      SEL_CALCFG:  rdMux = calCfgQ;
      SEL_CALSTAT: rdMux = calStatQ;
      default:     rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rdData <= '0;
    else if (strb.rdAct) rdData <= rdMux;
    else                 rdData <= '0;
  end

  // R3 R4
  req_bits_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSel == SEL_CTRL |=> ctrlQ[INIT_BIT] == 1'b0 && ctrlQ[TRAIN_BIT] == 1'b0);

  // R5
  cal_done_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSel == SEL_CALCFG |=> calStatQ[DONE_BIT]);

  // R8
  no_write_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrSel == SEL_NONE |=> $stable(ctrlQ) && $stable(calCfgQ) && $stable(calStatQ));

  // R2
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rdAct |=> rdData == '0);

endmodule

// File: rtl/dramstub_top.sv
module dramstub_top
  import dramstub_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              errRange,
  output logic              errUnimpl
);

  stubStrb_t strb;

  dramstub_ctrl #(.ADDR_W_P(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addr      (addr),
    .wrEn      (wrEn),
    .rdEn      (rdEn),
    .strb      (strb),
    .errRange  (errRange),
    .errUnimpl (errUnimpl)
  );

  dramstub_regs #(.DATA_W_P(DATA_W)) u_regs (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wrData (wrData),
    .rdData (rdData)
  );

endmodule

// File: tb/tb_dramstub_top.sv
`timescale 1ns/1ps
module tb_dramstub_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [11:0] addr = '0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        rdEn = 1'b0;
  logic [31:0] rdData;
  logic        errRange;
  logic        errUnimpl;

  always #2 clk = ~clk;

  dramstub_top dut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .errRange(errRange), .errUnimpl(errUnimpl)
  );

  typedef struct {
    logic [31:0] d;
    logic        rng;
    logic        unimp;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   nTests = 0;
  int   nFail = 0;
  bit   finished = 0;

  // Model of the register contents, built from the requirements
  logic [31:0] mCtrl, mCfg, mStat;

  function automatic void modelReset();
    mCtrl = 32'h8002_0000;
    mCfg  = 32'h07B0_0000;
    mStat = 32'h8000_0000;
  endfunction

  function automatic logic [31:0] modelRead(input logic [11:0] a);
    if (a == 12'h000) return mCtrl;
    if (a == 12'h0A8) return mCfg;
    if (a == 12'h0B0) return mStat;
    return 32'h0;
  endfunction

  task automatic doCycle(input logic [11:0] a, input logic we,
                         input logic [31:0] wd, input logic re, input string tag);
    exp_t e;
    logic mis, oor, impl;
    @(negedge clk);
    rstN = 1'b1; addr = a; wrEn = we; wrData = wd; rdEn = re;
    mis  = |a[1:0];
    oor  = mis || (a >= 12'h2E4);
    impl = !mis && (a == 12'h000 || a == 12'h0A8 || a == 12'h0B0);
    e.d     = re ? modelRead(a) : 32'h0;
    e.rng   = (we || re) && oor;
    e.unimp = (we || re) && !oor && !impl;
    e.tag   = tag;
    if (we && impl) begin
      if (a == 12'h000) mCtrl = wd & 32'h3FFF_FFFF;
      else if (a == 12'h0A8) begin mCfg = wd; mStat[31] = 1'b1; end
      else mStat = wd;
    end
    q.push_back(e);
  endtask

  task automatic resetCycle(input string tag);
    exp_t e;
    @(negedge clk);
    rstN = 1'b0; addr = 12'h2E4; wrEn = 1'b1; wrData = 32'hFFFF_FFFF; rdEn = 1'b1;
    modelReset();
    e.d = 32'h0; e.rng = 1'b0; e.unimp = 1'b0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic rd(input logic [11:0] a, input string tag);
    doCycle(a, 1'b0, 32'h0, 1'b1, tag);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    doCycle(a, 1'b1, d, 1'b0, tag);
  endtask

  // Monitor: compares one expected item per cycle, just after the edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      nTests++;
      if (rdData !== e.d || errRange !== e.rng || errUnimpl !== e.unimp) begin
        nFail++;
        $display("FAIL %s: got rdData=%h rng=%b unimp=%b, expected rdData=%h rng=%b unimp=%b",
                 e.tag, rdData, errRange, errUnimpl, e.d, e.rng, e.unimp);
      end
    end
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got no end of run, expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (2) @(posedge clk);
    resetCycle("R1 reset outputs");
    resetCycle("R1 reset outputs");
    rd(12'h000, "R1 ctrl reset value");
    rd(12'h0A8, "R1 cal setup reset value");
    rd(12'h0B0, "R1 cal status reset value");
    doCycle(12'h000, 1'b0, 32'h0, 1'b0, "R2 no read gives zero");

    wr(12'h000, 32'h8000_1234, "R3 init request write");
    rd(12'h000, "R3 init bit reads clear");
    wr(12'h000, 32'h4000_ABCD, "R4 training request write");
    rd(12'h000, "R4 training bit reads clear");
    wr(12'h000, 32'hC3FF_0001, "R4 both requests write");
    rd(12'h000, "R4 other bits kept");

    wr(12'h0B0, 32'h0000_0055, "R6 status write");
    rd(12'h0B0, "R6 status readback");
    wr(12'h0A8, 32'h1234_5678, "R5 cal setup write");
    rd(12'h0A8, "R5 cal setup readback");
    rd(12'h0B0, "R5 done flag set, rest kept");

    doCycle(12'h000, 1'b1, 32'h0000_0077, 1'b1, "R2 same-cycle read returns old");
    rd(12'h000, "R2 new value after write");

    rd(12'h004, "R8 unimplemented read");
    rd(12'h2E0, "R8 last unimplemented word");
    wr(12'h0AC, 32'hFFFF_FFFF, "R8 unimplemented write");
    rd(12'h0A8, "R8 cal setup untouched");
    rd(12'h0B0, "R8 cal status untouched");

    rd(12'h2E4, "R7 first out-of-range read");
    rd(12'hFFC, "R7 last word read");
    wr(12'h2E4, 32'hFFFF_FFFF, "R7 out-of-range write");
    rd(12'h000, "R7 ctrl untouched");

    wr(12'h001, 32'h0000_DEAD, "R9 misaligned write");
    rd(12'h000, "R9 ctrl untouched");
    rd(12'h0AA, "R9 misaligned read");
    wr(12'h0B2, 32'h0, "R9 misaligned status write");
    rd(12'h0B0, "R9 status untouched");

    rd(12'h3F0, "R7 range strobe before reset");
    resetCycle("R1 reset clears strobes");
    rd(12'h000, "R1 ctrl restored");
    rd(12'h0B0, "R1 status restored");
    doCycle(12'h000, 1'b0, 32'h0, 1'b0, "R2 idle after read");

    wait (q.size() == 0);
    repeat (2) @(posedge clk);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule